// File: doc/BRIEF.md
# Heap Load/Store Micro-Sequencer

This block runs the two heap-access instructions of a small accumulator-free register machine. On a start strobe it takes one 24-bit instruction word. If the opcode is a heap load or a heap store, it steps through a fixed micro-operation sequence, one step per clock. The sequence forms an effective heap address by adding a base register to an unsigned immediate offset, then moves one 32-bit word between the register file and a dedicated heap RAM.

Address formation always uses the same short staging path. The memory address register is cleared, loaded with the offset, and then summed with the base value, which has been staged in an intermediate buffer. Only after that does the heap port see an access. Data moves through the same buffer and the memory data register, so both directions share one set of staging registers.

Instruction fetch, program counter handling and every other instruction class belong to the surrounding processor. This unit only executes a word it has been handed and signals completion with a one-cycle pulse.

Top module: `heap_xfer_seq`

## Requirements
- R1: Instruction fields are opcode = instr[23:19], data register index = instr[18:16], base register index = instr[15:13], offset = instr[12:0]. Opcode 0x13 is heap load and opcode 0x14 is heap store.
- R2: A heap load reads heap[EA] exactly once and writes the word returned into the data register. EA = (low 16 bits of the base register + zero-extended offset) mod 65536.
- R3: A heap store writes the current value of the data register to heap[EA] exactly once, with EA formed as in R2. When the data register and the base register are the same register, the stored word is that register's value.
- R4: For a load, done is high in the 9th clock cycle after the cycle in which start was sampled. The register-file write takes place in the cycle just before done.
- R5: For a store, done is high in the 8th clock cycle after the cycle in which start was sampled. The heap write takes place in the cycle just before done.
- R6: Any other opcode completes with done and err both high in the 1st cycle after start is sampled, with no heap read, no heap write and no register write. err is never high without done.
- R7: A start raised while a sequence is in progress is ignored. The running instruction completes unchanged and only one done pulse is produced.
- R8: done is a single-cycle pulse, and exactly one pulse is produced per accepted instruction.
- R9: While reset is asserted, and after reset is released, done, err, heap read/write enables and the register write enable are low. A sequence interrupted by reset produces no done and no register write.
- R10: A load performs one register write and no heap write. A store performs no register write and no heap read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin executing instr (sampled only when idle) |
| instr | input | 24 | Instruction word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | High with done when the opcode was not a heap load or store |
| rf_raddr | output | 3 | Register file read index |
| rf_rdata | input | 32 | Register file read data, valid in the same cycle |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 3 | Register file write index |
| rf_wdata | output | 32 | Register file write data |
| heap_addr | output | 16 | Heap RAM address |
| heap_re | output | 1 | Heap read enable; data returned on the next cycle |
| heap_rdata | input | 32 | Heap read data |
| heap_we | output | 1 | Heap write enable |
| heap_wdata | output | 32 | Heap write data |

## Verification
The bench targets offsets and base values whose 16-bit sum overflows. A design without modulo wrap, or one that let base bits above 15 into the sum, would access the wrong address. It also covers the case where the data register is also the base register. An implementation that reused the wrong buffer content would store the base or overwrite it too early. Unknown opcodes are checked for silence at the heap and register-file ports, and a start pulse is injected mid-sequence. A sequencer that restarted or relatched its instruction would emit a second done pulse or perform a store. Exact latencies catch any dropped or extra micro-step, including a wrong capture cycle for the synchronous heap read.

// File: rtl/heap_xfer_pkg.sv
package heap_xfer_pkg;

  localparam int INSTR_W = 24;
  localparam int OP_W    = 5;
  localparam int IDX_W   = 3;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 32;

  localparam logic [OP_W-1:0] OP_LOAD_H  = 5'h13;
  localparam logic [OP_W-1:0] OP_STORE_H = 5'h14;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CLR,
    S_OFS,
    S_BASE,
    S_ADD,
    S_RD,
    S_CAP,
    S_MV,
    S_WB,
    S_SRC,
    S_TOMDR,
    S_WR,
    S_DONE
  } seq_state_e;

  typedef enum logic [1:0] {
    K_LOAD,
    K_STORE,
    K_BAD
  } op_kind_e;

  // One micro-step worth of enables
  typedef struct packed {
    logic ir_le;
    logic mar_clr;
    logic mar_ofs;
    logic mar_add;
    logic buf_rf;
    logic buf_mdr;
    logic mdr_heap;
    logic mdr_buf;
    logic rf_sel_data;
    logic rf_we;
    logic heap_re;
    logic heap_we;
  } uop_t;

endpackage

// File: rtl/heap_xfer_dec.sv
module heap_xfer_dec
  import heap_xfer_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W,
  parameter int OPC_WIDTH   = OP_W,
  parameter int IDX_WIDTH   = IDX_W,
  parameter int ADR_WIDTH   = ADDR_W,
  parameter logic [OPC_WIDTH-1:0] OPC_LOAD  = OP_LOAD_H,
  parameter logic [OPC_WIDTH-1:0] OPC_STORE = OP_STORE_H
) (
  input  logic [INSTR_WIDTH-1:0] word,
  output op_kind_e               kind,
  output logic [IDX_WIDTH-1:0]   data_idx,
  output logic [IDX_WIDTH-1:0]   base_idx,
  output logic [ADR_WIDTH-1:0]   ofs_ext
);

  localparam int OFS_WIDTH = INSTR_WIDTH - OPC_WIDTH - 2*IDX_WIDTH;
  localparam int OPC_LSB   = INSTR_WIDTH - OPC_WIDTH;
  localparam int DATA_LSB  = OPC_LSB - IDX_WIDTH;
  localparam int BASE_LSB  = DATA_LSB - IDX_WIDTH;

  logic [OPC_WIDTH-1:0] opc;
  logic [OFS_WIDTH-1:0] ofs_raw;

  assign opc      = word[INSTR_WIDTH-1:OPC_LSB];
  assign data_idx = word[OPC_LSB-1:DATA_LSB];
  assign base_idx = word[DATA_LSB-1:BASE_LSB];
  assign ofs_raw  = word[OFS_WIDTH-1:0];

  // Offset widening: zero-extend when the field is narrower than an address
  generate
    if (OFS_WIDTH < ADR_WIDTH) begin : g_ofs_pad
      assign ofs_ext = {{(ADR_WIDTH-OFS_WIDTH){1'b0}}, ofs_raw};
    end else begin : g_ofs_trunc
      assign ofs_ext = ofs_raw[ADR_WIDTH-1:0];
    end
  endgenerate

  always_comb begin
    if (opc == OPC_LOAD)       kind = K_LOAD;
    else if (opc == OPC_STORE) kind = K_STORE;
    else                       kind = K_BAD;
  end

endmodule

// File: rtl/heap_xfer_ctrl.sv
module heap_xfer_ctrl
  import heap_xfer_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  op_kind_e kind,
  output uop_t     uop,
  output logic     busy,
  output logic     done,
  output logic     err
);

  seq_state_e state_q, state_d;
  logic       err_q, err_d;

  // Next-state and micro-op decode
  always_comb begin
    state_d = state_q;
    err_d   = err_q;
    uop     = '0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          uop.ir_le = 1'b1;
          if (kind == K_BAD) begin
            state_d = S_DONE;
            err_d   = 1'b1;
          end else begin
            state_d = S_CLR;
            err_d   = 1'b0;
          end
        end
      end
      S_CLR: begin
        uop.mar_clr = 1'b1;
        state_d     = S_OFS;
      end
      S_OFS: begin
        uop.mar_ofs = 1'b1;
        state_d     = S_BASE;
      end
      S_BASE: begin
        uop.buf_rf = 1'b1;
        state_d    = S_ADD;
      end
      S_ADD: begin
        uop.mar_add = 1'b1;
        state_d     = (kind == K_LOAD) ? S_RD : S_SRC;
      end
      S_RD: begin
        uop.heap_re = 1'b1;
        state_d     = S_CAP;
      end
      S_CAP: begin
        uop.mdr_heap = 1'b1;
        state_d      = S_MV;
      end
      S_MV: begin
        uop.buf_mdr = 1'b1;
        state_d     = S_WB;
      end
      S_WB: begin
        uop.rf_we = 1'b1;
        state_d   = S_DONE;
      end
      S_SRC: begin
        uop.buf_rf      = 1'b1;
        uop.rf_sel_data = 1'b1;
        state_d         = S_TOMDR;
      end
      S_TOMDR: begin
        uop.mdr_buf = 1'b1;
        state_d     = S_WR;
      end
      S_WR: begin
        uop.heap_we = 1'b1;
        state_d     = S_DONE;
      end
      S_DONE: begin
        state_d = S_IDLE;
      end
      default: begin
        state_d = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = (state_q == S_DONE);
  assign err  = done & err_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R6
  AST_WB_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    uop.rf_we |=> done); // R4
  AST_HEAP_WR_BEFORE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    uop.heap_we |=> done); // R5
  AST_BAD_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    uop.heap_re |-> !err_q); // R6

endmodule

// File: rtl/heap_xfer_dp.sv
module heap_xfer_dp
  import heap_xfer_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W,
  parameter int IDX_WIDTH   = IDX_W,
  parameter int ADR_WIDTH   = ADDR_W,
  parameter int DAT_WIDTH   = DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  uop_t                   uop,
  input  logic [INSTR_WIDTH-1:0] instr,
  input  logic [IDX_WIDTH-1:0]   data_idx,
  input  logic [IDX_WIDTH-1:0]   base_idx,
  input  logic [ADR_WIDTH-1:0]   ofs_ext,
  input  logic [DAT_WIDTH-1:0]   rf_rdata,
  input  logic [DAT_WIDTH-1:0]   heap_rdata,
  output logic [INSTR_WIDTH-1:0] ir,
  output logic [IDX_WIDTH-1:0]   rf_raddr,
  output logic [IDX_WIDTH-1:0]   rf_waddr,
  output logic [DAT_WIDTH-1:0]   rf_wdata,
  output logic [ADR_WIDTH-1:0]   heap_addr,
  output logic [DAT_WIDTH-1:0]   heap_wdata
);

  logic [INSTR_WIDTH-1:0] ir_q, ir_d;
  logic [ADR_WIDTH-1:0]   mar_q, mar_d;
  logic [DAT_WIDTH-1:0]   mdr_q, mdr_d;
  logic [DAT_WIDTH-1:0]   buf_q, buf_d;
  logic [ADR_WIDTH-1:0]   ea_sum;

  // Address adder: only the low address bits of the staged base take part
  assign ea_sum = mar_q + buf_q[ADR_WIDTH-1:0];

  assign rf_raddr = uop.rf_sel_data ? data_idx : base_idx;

  always_comb begin
    ir_d = ir_q;
    if (uop.ir_le) ir_d = instr;
  end

  always_comb begin
    mar_d = mar_q;
    if (uop.mar_clr)      mar_d = '0;
    else if (uop.mar_ofs) mar_d = ofs_ext;
    else if (uop.mar_add) mar_d = ea_sum;
  end

  always_comb begin
    buf_d = buf_q;
    if (uop.buf_rf)       buf_d = rf_rdata;
    else if (uop.buf_mdr) buf_d = mdr_q;
  end

  always_comb begin
    mdr_d = mdr_q;
    if (uop.mdr_heap)     mdr_d = heap_rdata;
    else if (uop.mdr_buf) mdr_d = buf_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      buf_q <= '0;
    end else begin
      ir_q  <= ir_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
      buf_q <= buf_d;
    end
  end

  assign ir         = ir_q;
  assign rf_waddr   = data_idx;
  assign rf_wdata   = buf_q;
  assign heap_addr  = mar_q;
  assign heap_wdata = mdr_q;

  AST_MAR_HELD_AT_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    uop.heap_re |=> $stable(mar_q)); // R2
  AST_OFS_AFTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    uop.mar_clr |=> (mar_q == '0)); // R2

endmodule

// File: rtl/heap_xfer_seq.sv
module heap_xfer_seq
  import heap_xfer_pkg::*;
#(
  parameter int INSTR_WIDTH = INSTR_W,
  parameter int OPC_WIDTH   = OP_W,
  parameter int IDX_WIDTH   = IDX_W,
  parameter int ADR_WIDTH   = ADDR_W,
  parameter int DAT_WIDTH   = DATA_W,
  parameter int SYNC_STAGES = 2,
  parameter logic [OPC_WIDTH-1:0] OPC_LOAD  = OP_LOAD_H,
  parameter logic [OPC_WIDTH-1:0] OPC_STORE = OP_STORE_H
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [INSTR_WIDTH-1:0] instr,
  output logic                   done,
  output logic                   err,
  output logic [IDX_WIDTH-1:0]   rf_raddr,
  input  logic [DAT_WIDTH-1:0]   rf_rdata,
  output logic                   rf_we,
  output logic [IDX_WIDTH-1:0]   rf_waddr,
  output logic [DAT_WIDTH-1:0]   rf_wdata,
  output logic [ADR_WIDTH-1:0]   heap_addr,
  output logic                   heap_re,
  input  logic [DAT_WIDTH-1:0]   heap_rdata,
  output logic                   heap_we,
  output logic [DAT_WIDTH-1:0]   heap_wdata
);

  // Reset: asserted asynchronously, released through a flop chain
  logic [SYNC_STAGES-1:0] rst_chain_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_chain_q <= '0;
    else        rst_chain_q <= {rst_chain_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_chain_q[SYNC_STAGES-1];

  uop_t                   uop;
  logic                   busy;
  op_kind_e               kind;
  logic [INSTR_WIDTH-1:0] ir_w;
  logic [INSTR_WIDTH-1:0] dec_word;
  logic [IDX_WIDTH-1:0]   data_idx;
  logic [IDX_WIDTH-1:0]   base_idx;
  logic [ADR_WIDTH-1:0]   ofs_ext;

  // While idle the incoming word is classified; afterwards the latched one
  assign dec_word = busy ? ir_w : instr;

  heap_xfer_dec #(
    .INSTR_WIDTH (INSTR_WIDTH),
    .OPC_WIDTH   (OPC_WIDTH),
    .IDX_WIDTH   (IDX_WIDTH),
    .ADR_WIDTH   (ADR_WIDTH),
    .OPC_LOAD    (OPC_LOAD),
    .OPC_STORE   (OPC_STORE)
  ) i_dec (
    .word     (dec_word),
    .kind     (kind),
    .data_idx (data_idx),
    .base_idx (base_idx),
    .ofs_ext  (ofs_ext)
  );

  heap_xfer_ctrl i_ctrl (
    .clk   (clk),
    .rst_n (rst_int_n),
    .start (start),
    .kind  (kind),
    .uop   (uop),
    .busy  (busy),
    .done  (done),
    .err   (err)
  );

  heap_xfer_dp #(
    .INSTR_WIDTH (INSTR_WIDTH),
    .IDX_WIDTH   (IDX_WIDTH),
    .ADR_WIDTH   (ADR_WIDTH),
    .DAT_WIDTH   (DAT_WIDTH)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .uop        (uop),
    .instr      (instr),
    .data_idx   (data_idx),
    .base_idx   (base_idx),
    .ofs_ext    (ofs_ext),
    .rf_rdata   (rf_rdata),
    .heap_rdata (heap_rdata),
    .ir         (ir_w),
    .rf_raddr   (rf_raddr),
    .rf_waddr   (rf_waddr),
    .rf_wdata   (rf_wdata),
    .heap_addr  (heap_addr),
    .heap_wdata (heap_wdata)
  );

  assign rf_we   = uop.rf_we;
  assign heap_re = uop.heap_re;
  assign heap_we = uop.heap_we;

  AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && start) |=> $stable(ir_w)); // R7
  AST_SINGLE_PORT_OP: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones({heap_re, heap_we, rf_we}) <= 1); // R10

endmodule

// File: tb/test_heap_xfer_seq.sv
`timescale 1ns/1ps
module test_heap_xfer_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [23:0] instr;
  logic        done, err;
  logic [2:0]  rf_raddr, rf_waddr;
  logic [31:0] rf_rdata, rf_wdata;
  logic        rf_we;
  logic [15:0] heap_addr;
  logic        heap_re, heap_we;
  logic [31:0] heap_rdata, heap_wdata;

  always #2 clk = ~clk;

  heap_xfer_seq i_heap_xfer_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
    .done(done), .err(err),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .heap_addr(heap_addr), .heap_re(heap_re), .heap_rdata(heap_rdata),
    .heap_we(heap_we), .heap_wdata(heap_wdata)
  );

  function automatic logic [31:0] hfun(input logic [15:0] a);
    return {a ^ 16'hA5C3, a};
  endfunction

  // Bench-side register file, heap read model and access counters
  logic [31:0] rf_m [8];
  logic        tb_we = 1'b0;
  logic [2:0]  tb_wa = '0;
  logic [31:0] tb_wd = '0;
  logic        cnt_clr = 1'b0;
  logic [31:0] hrd = '0;
  int re_cnt = 0, we_cnt = 0, rfw_cnt = 0, done_cnt = 0;
  logic [15:0] wr_addr = '0;
  logic [31:0] wr_data = '0;

  assign rf_rdata   = rf_m[rf_raddr];
  assign heap_rdata = hrd;

  always @(posedge clk) begin
    if (tb_we)      rf_m[tb_wa] <= tb_wd;
    else if (rf_we) rf_m[rf_waddr] <= rf_wdata;
    if (heap_re) hrd <= hfun(heap_addr);
    if (cnt_clr) begin
      re_cnt <= 0; we_cnt <= 0; rfw_cnt <= 0; done_cnt <= 0;
    end else begin
      if (heap_re) re_cnt <= re_cnt + 1;
      if (heap_we) begin
        we_cnt  <= we_cnt + 1;
        wr_addr <= heap_addr;
        wr_data <= heap_wdata;
      end
      if (rf_we) rfw_cnt  <= rfw_cnt + 1;
      if (done)  done_cnt <= done_cnt + 1;
    end
  end

  int total = 0;
  int bad   = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rf_set(input logic [2:0] idx, input logic [31:0] val);
    @(negedge clk); tb_we = 1'b1; tb_wa = idx; tb_wd = val;
    @(negedge clk); tb_we = 1'b0;
  endtask

  task automatic clr_cnt();
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
  endtask

  // Issue one instruction; lat = cycle index (1 = cycle after start sampled) of done
  task automatic run(input logic [23:0] w, output int lat, output logic e, output logic d_after);
    @(negedge clk); start = 1'b1; instr = w;
    @(negedge clk); start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk); lat++;
    end
    e = err;
    @(negedge clk);
    d_after = done;
  endtask

  // Vector: {opcode[5], data reg[3], base reg[3], offset[13], base value[32]}
  localparam int NV = 7;
  localparam logic [55:0] VEC [NV] = '{
    {5'h13, 3'd2, 3'd5, 13'h0010, 32'h0000_1000},
    {5'h13, 3'd7, 3'd0, 13'h1FFF, 32'hABCD_F800},
    {5'h14, 3'd3, 3'd1, 13'h0000, 32'h0000_FFFF},
    {5'h14, 3'd4, 3'd4, 13'h0004, 32'h0000_FFFE},
    {5'h13, 3'd6, 3'd6, 13'h0100, 32'h1234_2000},
    {5'h15, 3'd1, 3'd2, 13'h0001, 32'h0000_0040},
    {5'h00, 3'd0, 3'd0, 13'h0000, 32'h0000_0000}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat;
    logic e, d_after;
    for (int k = 0; k < 8; k++) rf_m[k] = '0;
    rst_n = 1'b0; start = 1'b0; instr = '0;
    repeat (3) @(negedge clk);
    // R9: idle outputs during reset
    chk("R9", "outputs in reset", {27'b0, done, err, heap_re, heap_we, rf_we}, 32'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9", "outputs after reset", {27'b0, done, err, heap_re, heap_we, rf_we}, 32'h0);

    // Table walk: R1 field layout across load, store and illegal opcodes
    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      logic [4:0]  op;
      logic [2:0]  rg, bs;
      logic [12:0] of;
      logic [31:0] bv, src;
      logic [15:0] ea;
      v  = VEC[i];
      op = v[55:51]; rg = v[50:48]; bs = v[47:45]; of = v[44:32]; bv = v[31:0];
      src = (rg == bs) ? bv : (32'hC0DE_0000 | 32'(i));
      ea  = bv[15:0] + {3'b000, of};
      rf_set(bs, bv);
      if (rg != bs) rf_set(rg, src);
      clr_cnt();
      run(v[55:32], lat, e, d_after);
      chk("R8", "done after pulse", {31'b0, d_after}, 32'h0);
      chk("R8", "done pulse count", done_cnt, 1);
      if (op == 5'h13) begin
        chk("R4", "load latency", lat, 9);
        chk("R2", "heap reads", re_cnt, 1);
        chk("R2", "loaded value", rf_m[rg], hfun(ea));
        chk("R10", "load reg writes", rfw_cnt, 1);
        chk("R10", "load heap writes", we_cnt, 0);
        chk("R1", "load err", {31'b0, e}, 32'h0);
      end else if (op == 5'h14) begin
        chk("R5", "store latency", lat, 8);
        chk("R3", "store heap writes", we_cnt, 1);
        chk("R3", "store address", {16'h0, wr_addr}, {16'h0, ea});
        chk("R3", "store data", wr_data, src);
        chk("R10", "store reg writes", rfw_cnt, 0);
        chk("R10", "store heap reads", re_cnt, 0);
        chk("R1", "store err", {31'b0, e}, 32'h0);
      end else begin
        chk("R6", "illegal latency", lat, 1);
        chk("R6", "illegal err", {31'b0, e}, 32'h1);
        chk("R6", "illegal access count", re_cnt + we_cnt + rfw_cnt, 0);
      end
    end

    // R7: start during a running load is ignored
    rf_set(3'd1, 32'h0000_0100);
    clr_cnt();
    @(negedge clk); start = 1'b1; instr = {5'h13, 3'd2, 3'd1, 13'h0005};
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    @(negedge clk); start = 1'b1; instr = {5'h14, 3'd3, 3'd1, 13'h0009};
    @(negedge clk); start = 1'b0;
    repeat (15) @(negedge clk);
    chk("R7", "done pulses", done_cnt, 1);
    chk("R7", "no store issued", we_cnt, 0);
    chk("R7", "first load result", rf_m[2], hfun(16'h0105));

    // R9: reset in the middle of a load
    clr_cnt();
    @(negedge clk); start = 1'b1; instr = {5'h13, 3'd5, 3'd1, 13'h0001};
    @(negedge clk); start = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (12) @(negedge clk);
    chk("R9", "no done after abort", done_cnt, 0);
    chk("R9", "no reg write after abort", rfw_cnt, 0);
    clr_cnt();
    run({5'h13, 3'd5, 3'd1, 13'h0001}, lat, e, d_after);
    chk("R4", "load latency after reset", lat, 9);
    chk("R2", "load after reset", rf_m[5], hfun(16'h0101));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule